// File: doc/BRIEF.md
# Memory Event Performance Monitor

This block watches a memory controller and tallies what it does. It holds a set of counters. Counter 0 is a free-running clock-cycle counter. Each of the other counters tallies one event kind, picked by an 8-bit code. The controller delivers each event as a one-cycle strobe on the bit of `evt_i` whose index is that code. Software programs and reads the counters through a simple register port. A write takes effect at the clock edge where `req_valid` is high. A read returns its data one cycle later, marked by `rsp_valid`.

The cycle counter also acts as the master gate for the whole monitor. It is controlled by a state machine with three states:
- `CYC_IDLE`: stopped.
- `CYC_RUN`: counting.
- `CYC_FROZEN`: halted after the cycle counter wrapped.

The transitions are:
- IDLE→RUN when its control register is written with enable set.
- RUN→IDLE or FROZEN→IDLE when it is written with enable clear.
- RUN→FROZEN when the count wraps past all-ones.
- FROZEN→RUN when a write keeps enable set and moves the clear bit from 0 to 1.

Event counters advance only while this machine is in `CYC_RUN`. The interrupt output follows the cycle counter's overflow flag. Event counters stop at full scale on their own, raise their own flag and wait to be cleared.

Top module: `mem_perf_mon`

## Requirements
- R1: After reset, every count reads 0. Control register 0 reads 0. Every event control register reads 0x00000002, with only its clear bit set. `irq_o` is low.
- R2: The control register of counter n is at byte offset 4·n and its count at 0x20 + 4·n. In a control word, bit 0 is the overflow flag, bit 1 clear, bit 2 enable and bits 31:24 the event code. In `CYC_RUN`, counter 0 gains exactly one per clock edge. Enabling at edge e and disabling at edge d leaves d−e.
- R3: Counter 0 ignores every event strobe, and its code field always reads 0 whatever is written to it.
- R4: Event counter n gains one for each edge in `CYC_RUN` where its enable bit is set and bit `evt_i[code]` is high. Strobes on other codes leave it unchanged.
- R5: While the cycle machine is in `CYC_IDLE` or `CYC_FROZEN`, no counter changes unless software writes it.
- R6: When counter 0 passes all-ones, it wraps to 0, sets its overflow flag, raises `irq_o` and enters `CYC_FROZEN`. All counters then hold their values.
- R7: `irq_o` stays high until counter 0 is cleared through a 0-to-1 clear edge, or is re-enabled from `CYC_IDLE`. Writing enable again while already enabled, or disabling, keeps it high.
- R8: An event counter at all-ones that sees one more event stays at all-ones, sets its overflow flag and ignores events until it is cleared.
- R9: Counter 0 is zeroed, and its overflow flag cleared, only on a write that moves its clear bit from 0 to 1. Writing 1 over a stored 1, or writing 0, leaves the count as it is.
- R10: Writing 0 to an event counter's clear bit zeroes its count and its overflow flag. Writing 1 leaves them unchanged. The clear bit always reads back as 1.
- R11: Code 0x00, the cycle code, never advances an event counter. A code with no strobe simply never counts.
- R12: `rsp_valid` is high in the cycle after a read request and low otherwise. `rsp_rdata` carries the register value sampled at the request edge. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 2**EVT_W | One-cycle event strobes, bit index = event code |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Cycle-counter overflow interrupt |

## Verification
The properties on counter motion assume that every counter change caused by software comes from a register write. They are therefore conditioned on cycles with no request. The bench keeps to this by driving requests for exactly one cycle, at the falling edge, through its tasks. Increments are assumed to be at most one per edge. The bench keeps each counter's code and its strobes to single bits, so no counter can see two events at once.

The bench uses an 8-bit counter width so that both overflow paths can be reached in a few hundred cycles. It sweeps the event code of one counter over all 256 values. In each pass it strobes the selected code once while the cycle counter is stopped and once while it runs, then strobes every other code together.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    // Cycle-counter gate machine
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_RUN    = 2'd1,
        CYC_FROZEN = 2'd2
    } cyc_state_t;

    // Control-word field positions (decoded by software)
    localparam int BIT_OVF = 0;
    localparam int BIT_CLR = 1;
    localparam int BIT_EN  = 2;
    localparam int SEL_LSB = 24;
    localparam int SEL_W   = 8;

    // Address map
    localparam int CTRL_REGION = 0;   // 0x00..0x1F
    localparam int CNT_REGION  = 1;   // 0x20..0x3F

endpackage

// File: rtl/mpm_regport.sv
module mpm_regport
    import mpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [NUM_CNT-1:0][31:0]        ctrl_rd,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_rd,
    output logic [NUM_CNT-1:0]              ctrl_we,
    output logic                            rsp_valid,
    output logic [31:0]                     rsp_rdata
);

    localparam int REGION_W = ADDR_W - 5;

    logic [2:0]          slot;
    logic [REGION_W-1:0] region;
    logic                aligned;
    logic                is_ctrl;
    logic                is_cnt;
    logic [31:0]         rd_mux;

    assign slot    = req_addr[4:2];
    assign region  = req_addr[ADDR_W-1:5];
    assign aligned = (req_addr[1:0] == 2'b00);
    assign is_ctrl = aligned && (region == REGION_W'(CTRL_REGION));
    assign is_cnt  = aligned && (region == REGION_W'(CNT_REGION));

    always_comb begin
        ctrl_we = '0;
        rd_mux  = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (slot == 3'(i)) begin
                ctrl_we[i] = req_valid && req_write && is_ctrl;
                if (is_ctrl) rd_mux = ctrl_rd[i];
                if (is_cnt)  rd_mux = 32'(cnt_rd[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/mpm_cycle_ctl.sv
module mpm_cycle_ctl
    import mpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wr_en,
    input  logic             wr_clr,
    output cyc_state_t       state_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic [31:0]      ctrl_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cyc_state_t       state_q, state_d;
    logic             en_q, clr_q, ovf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_edge, wrap, enter_run;

    assign clr_edge  = we && wr_clr && !clr_q;
    assign wrap      = (state_q == CYC_RUN) && !clr_edge && (cnt_q == CNT_MAX);
    assign enter_run = (state_q == CYC_IDLE) && (state_d == CYC_RUN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: begin
                if (we && wr_en) state_d = CYC_RUN;
            end
            CYC_RUN: begin
                if (we && !wr_en) state_d = CYC_IDLE;
                else if (wrap)    state_d = CYC_FROZEN;
            end
            CYC_FROZEN: begin
                if (we && !wr_en)  state_d = CYC_IDLE;
                else if (clr_edge) state_d = CYC_RUN;
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clr_q <= 1'b0;
            ovf_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (we) begin
                en_q  <= wr_en;
                clr_q <= wr_clr;
            end
            if (clr_edge)                cnt_q <= '0;
            else if (state_q == CYC_RUN) cnt_q <= cnt_q + 1'b1;
            if (clr_edge || enter_run)   ovf_q <= 1'b0;
            else if (wrap)               ovf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        state_o         = state_q;
        run_o           = (state_q == CYC_RUN);
        cnt_o           = cnt_q;
        ovf_o           = ovf_q;
        irq_o           = ovf_q;
        ctrl_o          = '0;
        ctrl_o[BIT_EN]  = en_q;
        ctrl_o[BIT_CLR] = clr_q;
        ctrl_o[BIT_OVF] = ovf_q;
    end

endmodule

// File: rtl/mpm_evt_counter.sv
module mpm_evt_counter
    import mpm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   wr_en,
    input  logic                   wr_clr,
    input  logic [EVT_W-1:0]       wr_sel,
    input  logic                   gate,
    input  logic [(1<<EVT_W)-1:0]  evt_i,
    output logic [CNT_W-1:0]       cnt_o,
    output logic                   ovf_o,
    output logic [31:0]            ctrl_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             en_q, ovf_q;
    logic [EVT_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = gate && en_q && !ovf_q && (sel_q != '0) && evt_i[sel_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
            ovf_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (we) begin
                en_q  <= wr_en;
                sel_q <= wr_sel;
            end
            if (we && !wr_clr) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (hit) begin
                if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
                else                  cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cnt_o                   = cnt_q;
        ovf_o                   = ovf_q;
        ctrl_o                  = '0;
        ctrl_o[SEL_LSB +: EVT_W] = sel_q;
        ctrl_o[BIT_EN]          = en_q;
        ctrl_o[BIT_CLR]         = 1'b1;
        ctrl_o[BIT_OVF]         = ovf_q;
    end

endmodule

// File: rtl/mem_perf_mon.sv
module mem_perf_mon
    import mpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int EVT_W   = 8,
    parameter int ADDR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<EVT_W)-1:0] evt_i,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic                  irq_o
);

    logic [NUM_CNT-1:0][31:0]      ctrl_all;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CNT-1:0]            ovf_all;
    logic [NUM_CNT-1:0]            ctrl_we;
    logic                          wr_en, wr_clr;
    logic [EVT_W-1:0]              wr_sel;
    logic                          cyc_run;
    cyc_state_t                    cyc_state;
    logic                          unused_wdata;

    assign wr_en        = req_wdata[BIT_EN];
    assign wr_clr       = req_wdata[BIT_CLR];
    assign wr_sel       = req_wdata[SEL_LSB +: EVT_W];
    assign unused_wdata = ^{req_wdata[SEL_LSB-1:BIT_EN+1], req_wdata[BIT_OVF]};

    mpm_regport #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ctrl_rd   (ctrl_all),
        .cnt_rd    (cnt_all),
        .ctrl_we   (ctrl_we),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    mpm_cycle_ctl #(.CNT_W(CNT_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl_we[0]),
        .wr_en   (wr_en),
        .wr_clr  (wr_clr),
        .state_o (cyc_state),
        .run_o   (cyc_run),
        .cnt_o   (cnt_all[0]),
        .ovf_o   (ovf_all[0]),
        .ctrl_o  (ctrl_all[0]),
        .irq_o   (irq_o)
    );

    for (genvar g = 1; g < NUM_CNT; g++) begin : g_evt
        mpm_evt_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (ctrl_we[g]),
            .wr_en  (wr_en),
            .wr_clr (wr_clr),
            .wr_sel (wr_sel),
            .gate   (cyc_run),
            .evt_i  (evt_i),
            .cnt_o  (cnt_all[g]),
            .ovf_o  (ovf_all[g]),
            .ctrl_o (ctrl_all[g])
        );
    end

endmodule

// File: rtl/mpm_checker.sv
module mpm_checker
    import mpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_write,
    input logic                          rsp_valid,
    input logic                          irq_o,
    input cyc_state_t                    cyc_state,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_CNT-1:0]            ovf_all
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_rsp_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_cyc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == CYC_RUN && !req_valid && cnt_all[0] != CNT_MAX)
        |=> cnt_all[0] == CNT_W'($past(cnt_all[0]) + 1'b1));

    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state != CYC_RUN && !req_valid) |=> $stable(cnt_all));

    p_frozen_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == CYC_FROZEN) |-> irq_o);

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(req_valid && req_write)) |=> irq_o);

    for (genvar i = 1; i < NUM_CNT; i++) begin : g_evt_chk
        p_evt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_all[i] |-> (cnt_all[i] == CNT_MAX));

        p_evt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> (cnt_all[i] == $past(cnt_all[i]) ||
                            cnt_all[i] == CNT_W'($past(cnt_all[i]) + 1'b1)));
    end

endmodule

bind mem_perf_mon mpm_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .irq_o     (irq_o),
    .cyc_state (cyc_state),
    .cnt_all   (cnt_all),
    .ovf_all   (ovf_all)
);

// File: tb/mem_perf_mon_test.sv
module mem_perf_mon_test;

    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 8;
    localparam int EVT_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_EVT = 1 << EVT_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt;
    logic               req_valid, req_write;
    logic [ADDR_W-1:0]  req_addr;
    logic [31:0]        req_wdata;
    logic               rsp_valid;
    logic [31:0]        rsp_rdata;
    logic               irq;
    logic [31:0]        d;
    int                 n_run = 0;
    int                 n_fail = 0;
    bit                 done = 1'b0;

    mem_perf_mon #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] CA(int n); return 8'(4 * n); endfunction
    function automatic logic [7:0] NA(int n); return 8'(32 + 4 * n); endfunction
    function automatic logic [31:0] ctl(logic [7:0] sel, logic en, logic clr);
        return {sel, 21'b0, en, clr, 1'b0};
    endfunction
    function automatic logic [NUM_EVT-1:0] one(int code);
        logic [NUM_EVT-1:0] v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rsp_valid", 32'(rsp_valid), 32'd1);
        v = rsp_rdata;
    endtask

    task automatic rdc(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic pulse(logic [NUM_EVT-1:0] v);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        evt = '0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R12 rsp idle", 32'(rsp_valid), 32'd0);
        rdc("R1 ctrl0", CA(0), 32'h0);
        for (int n = 1; n < NUM_CNT; n++) rdc("R1 evt ctrl", CA(n), 32'h2);
        for (int n = 0; n < NUM_CNT; n++) rdc("R1 count", NA(n), 32'h0);
        rdc("R12 unmapped", 8'h40, 32'h0);

        // R2, R3, R9 cycle counter
        wr(CA(0), 32'hAB00_0000);
        rdc("R3 ctrl0 sel ignored", CA(0), 32'h0);
        wr(CA(0), 32'hFF00_0006);          // enable + clear edge at edge e
        evt = '1;                          // R3: strobes must not matter
        repeat (7) @(negedge clk);
        wr(CA(0), ctl(8'h00, 1'b0, 1'b1)); // disable at e+8
        evt = '0;
        rdc("R2 cycle count", NA(0), 32'd8);
        rdc("R3 ctrl0 readback", CA(0), 32'h2);
        wr(CA(0), ctl(8'h00, 1'b0, 1'b1));
        rdc("R9 clear 1 over 1", NA(0), 32'd8);
        wr(CA(0), 32'h0);
        rdc("R9 clear write 0", NA(0), 32'd8);
        rdc("R5 idle holds", NA(0), 32'd8);
        wr(CA(0), ctl(8'h00, 1'b0, 1'b1));
        rdc("R9 clear edge", NA(0), 32'd0);

        // R4, R11, R5: sweep all codes on counter 1
        for (int s = 0; s < NUM_EVT; s++) begin
            wr(CA(0), 32'h0);
            wr(CA(1), ctl(8'(s), 1'b1, 1'b0));
            pulse(one(s));                   // cycle counter idle: ignored
            wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
            pulse(one(s));
            pulse(~one(s));
            wr(CA(0), 32'h0);
            rd(NA(1), d);
            if (s == 0) check("R11 code 0 never counts", d, 32'd0);
            else        check("R4 sweep count", d, 32'd1);
        end

        // R4, R10: three counters concurrently
        wr(CA(1), ctl(8'h20, 1'b1, 1'b0));
        wr(CA(2), ctl(8'h31, 1'b1, 1'b0));
        wr(CA(3), ctl(8'h37, 1'b0, 1'b0));
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
        for (int k = 0; k < 7; k++) begin
            logic [NUM_EVT-1:0] v;
            v = one(8'h37) | one(8'h05);
            if (k < 3) v = v | one(8'h20);
            if (k < 5) v = v | one(8'h31);
            pulse(v);
        end
        wr(CA(3), ctl(8'h37, 1'b1, 1'b1));   // enable, clear bit 1: no zeroing
        pulse(one(8'h37));
        pulse(one(8'h37));
        wr(CA(0), 32'h0);
        rdc("R4 counter1", NA(1), 32'd3);
        rdc("R4 counter2", NA(2), 32'd5);
        rdc("R4 disabled then 2", NA(3), 32'd2);
        rdc("R10 ctrl3 readback", CA(3), 32'h3700_0006);

        // R8, R10: event saturation
        wr(CA(2), ctl(8'h21, 1'b1, 1'b0));
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
        evt = one(8'h21);
        repeat (130) @(negedge clk);
        evt = '0;
        wr(CA(0), ctl(8'h00, 1'b1, 1'b0));
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
        evt = one(8'h21);
        repeat (130) @(negedge clk);
        evt = '0;
        wr(CA(0), 32'h0);
        check("R8 no cycle irq", 32'(irq), 32'd0);
        rdc("R8 saturated", NA(2), 32'hFF);
        rdc("R8 flag", CA(2), 32'h2100_0007);
        wr(CA(2), ctl(8'h21, 1'b1, 1'b0));
        rdc("R10 cleared count", NA(2), 32'h0);
        rdc("R10 cleared flag", CA(2), 32'h2100_0006);
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
        for (int k = 0; k < 3; k++) pulse(one(8'h21));
        wr(CA(0), 32'h0);
        rdc("R8 counts again", NA(2), 32'd3);

        // R6, R7: cycle overflow, re-enable path
        wr(CA(1), ctl(8'h04, 1'b1, 1'b0));
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));   // edge e
        evt = one(8'h04);
        repeat (10) @(negedge clk);
        evt = '0;
        repeat (290) @(negedge clk);
        for (int k = 0; k < 5; k++) pulse(one(8'h04));
        check("R6 irq raised", 32'(irq), 32'd1);
        rdc("R6 wrapped", NA(0), 32'd0);
        rdc("R6 ctrl0 flag", CA(0), 32'h7);
        rdc("R6 frozen event", NA(1), 32'd10);
        wr(CA(0), ctl(8'h00, 1'b1, 1'b0));
        check("R7 enable again keeps irq", 32'(irq), 32'd1);
        wr(CA(0), 32'h0);
        check("R7 disable keeps irq", 32'(irq), 32'd1);
        wr(CA(0), ctl(8'h00, 1'b1, 1'b0));
        check("R7 re-enable drops irq", 32'(irq), 32'd0);

        // R6, R7, R9: second overflow, clear-edge path
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));
        repeat (300) @(negedge clk);
        check("R6 irq second", 32'(irq), 32'd1);
        wr(CA(0), ctl(8'h00, 1'b1, 1'b0));
        check("R7 no edge keeps irq", 32'(irq), 32'd1);
        wr(CA(0), ctl(8'h00, 1'b1, 1'b1));   // clear edge at c
        check("R7 clear edge drops irq", 32'(irq), 32'd0);
        wr(CA(0), 32'h0);                    // c+1
        rdc("R9 resumed from zero", NA(0), 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule